// File: doc/BRIEF.md
# Exception Priority Resolver

This block decides which single exception a processor core should take next. Every cycle it looks at the pending system exception requests and at a bank of peripheral interrupt lines. It drops each request that is disabled, unimplemented or masked. From the requests that remain it reports the most urgent one as a vector number. Vector numbers start at zero. The sixteen lowest numbers belong to system exceptions, and peripheral line `n` is reported as vector `16+n`.

Three system exceptions have fixed urgency above every programmable level. They are the reset request, the non-maskable interrupt and the hard fault. Three configurable fault exceptions, a supervisor-call slot, a deferred-service slot and a tick-timer slot take their level from a small system-priority register set. Peripheral lines take their level and their enable from their own register bank, which is written through simple strobe ports. A single global mask pin removes every request from selection except the three fixed ones.

The outputs are level signals. They stay valid for as long as the winning request stays pending. There is no handshake and no back-pressure: the consumer samples `exc_valid`/`exc_vec`, and the source withdraws its request once the exception has been taken. `pend_vec` is a status field. It shows the most urgent enabled request while ignoring the global mask.

Top module: `exc_arbiter`

## Requirements
- R1: A system request on slot `s` is reported as vector `s`, and peripheral line `n` is reported as vector `16+n`.
- R2: Slots 0, 7, 8, 9, 10, 12 and 13 are unimplemented. A request on them alone leaves `exc_valid` low and `pend_vec` at 0.
- R3: Programmable levels are 4 bits wide, and a lower value is more urgent. Between requests of equal level, the lower vector number wins.
- R4: Slot 1 (reset) beats slot 2 (NMI), which beats slot 3 (hard fault), which beats any request at any programmable level.
- R5: Slots 2 and 3 have no enable. Slots 4, 5 and 6 are eligible only while `fault_en[s-4]` is 1. A peripheral line is eligible only while its enable bit is 1.
- R6: A pulse on `en_we` with `en_vec` in 16..16+NUM_IRQ-1 loads `en_val` into the enable of line `en_vec-16`. With `en_vec` below 16 (or past the last line), the write changes no enable, and `cfg_err` is 1 in the following cycle. `cfg_err` is 0 otherwise.
- R7: While `glb_mask` is 1, only slots 1, 2 and 3 can drive `exc_valid`.
- R8: Slots 4, 5, 6, 11, 14 and 15 use the level last written through `sp_we/sp_slot/sp_val`. Writes to any other slot are ignored. `ip_we/ip_idx/ip_val` sets the level of peripheral line `ip_idx`.
- R9: When no request is eligible, `exc_valid` is 0 and `exc_vec` is 0. `pend_vec` reports the winner among enabled requests while ignoring `glb_mask`, and reads 0 when there is none.
- R10: The outputs change at the clock edge that samples the request inputs. A configuration write affects selection from the edge after the write edge.
- R11: After reset, all enables, levels, `exc_valid`, `exc_vec`, `pend_vec` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_req | input | 16 | Pending flags for system slots 0..15 |
| irq_req | input | NUM_IRQ | Peripheral request lines |
| fault_en | input | 3 | Enables for fault slots 4, 5, 6 |
| glb_mask | input | 1 | Global mask; exempts slots 1..3 |
| en_we | input | 1 | Peripheral enable write strobe |
| en_vec | input | VEC_W | Vector number addressed by the enable write |
| en_val | input | 1 | Enable value written |
| ip_we | input | 1 | Peripheral level write strobe |
| ip_idx | input | IDX_W | Peripheral line addressed |
| ip_val | input | PRIO_W | Level written |
| sp_we | input | 1 | System level write strobe |
| sp_slot | input | 4 | System slot addressed |
| sp_val | input | PRIO_W | Level written |
| exc_valid | output | 1 | An eligible request exists |
| exc_vec | output | VEC_W | Winning vector, 0 when none |
| pend_vec | output | VEC_W | Most urgent enabled request, ignoring the mask |
| cfg_err | output | 1 | Previous enable write addressed a non-peripheral vector |

## Verification
The bench goes after ties at equal level. A design that compares with the wrong sense hands those to the higher vector. It requests the unimplemented holes, which a resolver that fails to gate them would report as vectors 7 or 12. It writes enables aimed at system slots. An unguarded address subtraction would then flip some peripheral enable, and the bench sees that line start or stop winning. It also raises the mask while peripheral and tick requests are pending. A design that exempts the wrong slots, or that also masks `pend_vec`, shows a wrong winner or a zero status field.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SYS_SLOTS = 16;
  // slots present in the system range
  localparam logic [15:0] IMPL_MASK  = 16'b1100_1000_0111_1110;
  // slots whose level comes from the system-priority registers
  localparam logic [15:0] PROG_MASK  = 16'b1100_1000_0111_0000;
  // slots with fixed urgency, ignoring the global mask
  localparam logic [15:0] FIXED_MASK = 16'b0000_0000_0000_1110;
  // slots with an individual enable bit (fault_en index = slot-4)
  localparam int FAULT_LO = 4;
  localparam int FAULT_HI = 6;
  // programmable levels sit above the three fixed levels 0,1,2
  localparam int LVL_OFS = 3;

  typedef enum logic [1:0] {
    SRC_HOLE  = 2'd0,
    SRC_FIXED = 2'd1,
    SRC_PROG  = 2'd2
  } sys_kind_e;

  function automatic sys_kind_e kind_of(input int slot);
    if (FIXED_MASK[slot]) return SRC_FIXED;
    if (PROG_MASK[slot])  return SRC_PROG;
    return SRC_HOLE;
  endfunction
endpackage

// File: rtl/exc_cfg_regs.sv
module exc_cfg_regs
  import exc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 4,
  localparam int VEC_W  = $clog2(SYS_SLOTS + NUM_IRQ),
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en_we,
  input  logic [VEC_W-1:0]                  en_vec,
  input  logic                              en_val,
  input  logic                              ip_we,
  input  logic [IDX_W-1:0]                  ip_idx,
  input  logic [PRIO_W-1:0]                 ip_val,
  input  logic                              sp_we,
  input  logic [3:0]                        sp_slot,
  input  logic [PRIO_W-1:0]                 sp_val,
  output logic [NUM_IRQ-1:0]                irq_en,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0]    irq_pri,
  output logic [SYS_SLOTS-1:0][PRIO_W-1:0]  sys_pri,
  output logic                              cfg_err
);
  localparam int NV = SYS_SLOTS + NUM_IRQ;

  logic en_in_range;
  assign en_in_range = (int'(en_vec) >= SYS_SLOTS) && (int'(en_vec) < NV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= '0;
      irq_pri <= '0;
      sys_pri <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= en_we && !en_in_range;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (en_we && en_in_range && int'(en_vec) == SYS_SLOTS + i) irq_en[i] <= en_val;
        if (ip_we && int'(ip_idx) == i) irq_pri[i] <= ip_val;
      end
      for (int s = 0; s < SYS_SLOTS; s++) begin
        if (sp_we && int'(sp_slot) == s && PROG_MASK[s]) sys_pri[s] <= sp_val;
      end
    end
  end

  // R6: an enable write aimed below the peripheral range touches nothing and flags
  a_r6_sys_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && int'(en_vec) < SYS_SLOTS) |=> (cfg_err && $stable(irq_en)));

  // R6: a write into the peripheral range raises no flag
  a_r6_good_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && int'(en_vec) >= SYS_SLOTS && int'(en_vec) < NV) |=> !cfg_err);

  // R8: system-level writes to fixed or absent slots leave the register set alone
  a_r8_fixed_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && !PROG_MASK[sp_slot]) |=> $stable(sys_pri));
endmodule

// File: rtl/exc_candidates.sv
module exc_candidates
  import exc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 4,
  localparam int NV     = SYS_SLOTS + NUM_IRQ,
  localparam int LVL_W  = PRIO_W + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SYS_SLOTS-1:0]              sys_req,
  input  logic [NUM_IRQ-1:0]                irq_req,
  input  logic [2:0]                        fault_en,
  input  logic                              glb_mask,
  input  logic [NUM_IRQ-1:0]                irq_en,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0]    irq_pri,
  input  logic [SYS_SLOTS-1:0][PRIO_W-1:0]  sys_pri,
  output logic [NV-1:0]                     pend_ok,
  output logic [NV-1:0]                     elig_ok,
  output logic [NV-1:0][LVL_W-1:0]          lvl
);
  generate
    for (genvar s = 0; s < SYS_SLOTS; s++) begin : g_sys
      logic gate;
      if (s >= FAULT_LO && s <= FAULT_HI) begin : g_fault
        assign gate = fault_en[s-FAULT_LO];
      end else begin : g_nogate
        assign gate = 1'b1;
      end
      assign pend_ok[s] = IMPL_MASK[s] && sys_req[s] && gate;
      assign elig_ok[s] = pend_ok[s] && (!glb_mask || FIXED_MASK[s]);
      assign lvl[s] = (kind_of(s) == SRC_FIXED) ? LVL_W'(s - 1)
                    : ({1'b0, sys_pri[s]} + LVL_W'(LVL_OFS));
    end
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      assign pend_ok[SYS_SLOTS+i] = irq_req[i] && irq_en[i];
      assign elig_ok[SYS_SLOTS+i] = pend_ok[SYS_SLOTS+i] && !glb_mask;
      assign lvl[SYS_SLOTS+i]     = {1'b0, irq_pri[i]} + LVL_W'(LVL_OFS);
    end
  endgenerate

  // R7: with the mask up, no peripheral line reaches the selection
  a_r7_mask_gates_lines: assert property (@(posedge clk) disable iff (!rst_n)
    glb_mask |-> (elig_ok[NV-1:SYS_SLOTS] == '0));

  // R5: NMI needs no enable and survives the mask
  a_r5_nmi_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req[2] |-> elig_ok[2]);

  // R2: holes never become candidates
  a_r2_holes_dead: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_ok[SYS_SLOTS-1:0] & ~IMPL_MASK) == '0);
endmodule

// File: rtl/exc_min_tree.sv
module exc_min_tree #(
  parameter int N      = 32,
  parameter int LVL_W  = 5,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int LEAVES = 1 << IW
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][LVL_W-1:0] lvl,
  output logic                    any,
  output logic [IW-1:0]           win
);
  logic             nv [1:2*LEAVES-1];
  logic [LVL_W-1:0] nl [1:2*LEAVES-1];
  logic [IW-1:0]    ni [1:2*LEAVES-1];

  generate
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      assign ni[LEAVES+i] = IW'(i);
      if (i < N) begin : g_real
        assign nv[LEAVES+i] = vld[i];
        assign nl[LEAVES+i] = lvl[i];
      end else begin : g_pad
        assign nv[LEAVES+i] = 1'b0;
        assign nl[LEAVES+i] = '0;
      end
    end
    // the left subtree always holds lower vectors, so ties go left
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
      logic take_left;
      assign take_left = nv[2*n] && (!nv[2*n+1] || (nl[2*n] <= nl[2*n+1]));
      assign nv[n] = nv[2*n] || nv[2*n+1];
      assign nl[n] = take_left ? nl[2*n] : nl[2*n+1];
      assign ni[n] = take_left ? ni[2*n] : ni[2*n+1];
    end
  endgenerate

  assign any = nv[1];
  assign win = nv[1] ? ni[1] : '0;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 4,
  localparam int VEC_W  = $clog2(SYS_SLOTS + NUM_IRQ),
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          sys_req,
  input  logic [NUM_IRQ-1:0]   irq_req,
  input  logic [2:0]           fault_en,
  input  logic                 glb_mask,
  input  logic                 en_we,
  input  logic [VEC_W-1:0]     en_vec,
  input  logic                 en_val,
  input  logic                 ip_we,
  input  logic [IDX_W-1:0]     ip_idx,
  input  logic [PRIO_W-1:0]    ip_val,
  input  logic                 sp_we,
  input  logic [3:0]           sp_slot,
  input  logic [PRIO_W-1:0]    sp_val,
  output logic                 exc_valid,
  output logic [VEC_W-1:0]     exc_vec,
  output logic [VEC_W-1:0]     pend_vec,
  output logic                 cfg_err
);
  localparam int NV    = SYS_SLOTS + NUM_IRQ;
  localparam int LVL_W = PRIO_W + 1;

  logic [NUM_IRQ-1:0]               irq_en;
  logic [NUM_IRQ-1:0][PRIO_W-1:0]   irq_pri;
  logic [SYS_SLOTS-1:0][PRIO_W-1:0] sys_pri;
  logic [NV-1:0]                    pend_ok, elig_ok;
  logic [NV-1:0][LVL_W-1:0]         lvl;
  logic                             any_e, any_p;
  logic [VEC_W-1:0]                 win_e, win_p;

  exc_cfg_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_vec(en_vec), .en_val(en_val),
    .ip_we(ip_we), .ip_idx(ip_idx), .ip_val(ip_val),
    .sp_we(sp_we), .sp_slot(sp_slot), .sp_val(sp_val),
    .irq_en(irq_en), .irq_pri(irq_pri), .sys_pri(sys_pri), .cfg_err(cfg_err)
  );

  exc_candidates #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_cand (
    .clk(clk), .rst_n(rst_n),
    .sys_req(sys_req), .irq_req(irq_req), .fault_en(fault_en), .glb_mask(glb_mask),
    .irq_en(irq_en), .irq_pri(irq_pri), .sys_pri(sys_pri),
    .pend_ok(pend_ok), .elig_ok(elig_ok), .lvl(lvl)
  );

  exc_min_tree #(.N(NV), .LVL_W(LVL_W)) u_pick_elig (
    .vld(elig_ok), .lvl(lvl), .any(any_e), .win(win_e)
  );

  exc_min_tree #(.N(NV), .LVL_W(LVL_W)) u_pick_pend (
    .vld(pend_ok), .lvl(lvl), .any(any_p), .win(win_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_vec   <= '0;
      pend_vec  <= '0;
    end else begin
      exc_valid <= any_e;
      exc_vec   <= any_e ? win_e : '0;
      pend_vec  <= any_p ? win_p : '0;
    end
  end

  // R2: a reported system vector is always an implemented slot
  a_r2_no_hole_vector: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (int'(exc_vec) >= SYS_SLOTS || IMPL_MASK[exc_vec[3:0]]));

  // R9: idle output reads zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> (exc_vec == '0));

  // R9: anything eligible is also pending, so the status field is nonzero
  a_r9_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (pend_vec != '0));

  // R4: a reset request wins one edge later
  a_r4_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req[1] |=> (exc_valid && exc_vec == VEC_W'(1)));

  // R4: NMI wins when reset is absent
  a_r4_nmi_second: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req[2] && !sys_req[1]) |=> (exc_valid && exc_vec == VEC_W'(2)));

  // R7: mask up and no fixed request means nothing is signalled
  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_mask && (sys_req[3:1] == 3'b000)) |=> !exc_valid);
endmodule

// File: tb/exc_arbiter_tb.sv
module exc_arbiter_tb_top;
  localparam int NI = 16;
  localparam int PW = 4;
  localparam int VW = 5;
  localparam int IW = 4;
  localparam int NV = 16 + NI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 4 time units = 250 MHz with 1 ns units

  logic [15:0]   sys_req = '0;
  logic [NI-1:0] irq_req = '0;
  logic [2:0]    fault_en = '0;
  logic          glb_mask = 1'b0;
  logic          en_we = 1'b0;
  logic [VW-1:0] en_vec = '0;
  logic          en_val = 1'b0;
  logic          ip_we = 1'b0;
  logic [IW-1:0] ip_idx = '0;
  logic [PW-1:0] ip_val = '0;
  logic          sp_we = 1'b0;
  logic [3:0]    sp_slot = '0;
  logic [PW-1:0] sp_val = '0;
  logic          exc_valid;
  logic [VW-1:0] exc_vec;
  logic [VW-1:0] pend_vec;
  logic          cfg_err;

  exc_arbiter #(.NUM_IRQ(NI), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_req(sys_req), .irq_req(irq_req),
    .fault_en(fault_en), .glb_mask(glb_mask),
    .en_we(en_we), .en_vec(en_vec), .en_val(en_val),
    .ip_we(ip_we), .ip_idx(ip_idx), .ip_val(ip_val),
    .sp_we(sp_we), .sp_slot(sp_slot), .sp_val(sp_val),
    .exc_valid(exc_valid), .exc_vec(exc_vec), .pend_vec(pend_vec), .cfg_err(cfg_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R11";
  int m_en [NI];
  int m_ip [NI];
  int m_sp [16];

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit prog_slot(input int s);
    return (s == 4 || s == 5 || s == 6 || s == 11 || s == 14 || s == 15);
  endfunction

  // behavioural reference: scan all vectors in ascending order, keep strict minimum
  function automatic void predict(output int win, output int pend);
    int bw = 1000;
    int bp = 1000;
    win = 0;
    pend = 0;
    for (int v = 0; v < NV; v++) begin
      int lv = -1;
      if (v >= 16) begin
        if (irq_req[v-16] && m_en[v-16] != 0) lv = m_ip[v-16] + 3;
      end else if (sys_req[v]) begin
        if (v == 1) lv = 0;
        else if (v == 2) lv = 1;
        else if (v == 3) lv = 2;
        else if (v >= 4 && v <= 6) begin
          if (fault_en[v-4]) lv = m_sp[v] + 3;
        end else if (prog_slot(v)) lv = m_sp[v] + 3;
      end
      if (lv >= 0) begin
        if (lv < bp) begin bp = lv; pend = v; end
        if ((!glb_mask || v <= 3) && lv < bw) begin bw = lv; win = v; end
      end
    end
  endfunction

  // called just after a falling edge with inputs set; returns after the next falling edge
  task automatic cycle();
    int w, p, e;
    predict(w, p);
    e = (en_we && int'(en_vec) < 16) ? 1 : 0;
    if (en_we && int'(en_vec) >= 16) m_en[int'(en_vec) - 16] = en_val ? 1 : 0;
    if (ip_we) m_ip[int'(ip_idx)] = int'(ip_val);
    if (sp_we && prog_slot(int'(sp_slot))) m_sp[int'(sp_slot)] = int'(sp_val);
    @(posedge clk);
    #1;
    chk("exc_valid", int'(exc_valid), (w != 0) ? 1 : 0);
    chk("exc_vec", int'(exc_vec), w);
    chk("pend_vec", int'(pend_vec), p);
    chk("cfg_err", int'(cfg_err), e);
    en_we = 1'b0;
    ip_we = 1'b0;
    sp_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_en(input int v, input bit val);
    en_we = 1'b1; en_vec = VW'(v); en_val = val; cycle();
  endtask
  task automatic wr_ip(input int i, input int val);
    ip_we = 1'b1; ip_idx = IW'(i); ip_val = PW'(val); cycle();
  endtask
  task automatic wr_sp(input int s, input int val);
    sp_we = 1'b1; sp_slot = 4'(s); sp_val = PW'(val); cycle();
  endtask

  bit done = 1'b0;

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) begin m_en[i] = 0; m_ip[i] = 0; end
    for (int s = 0; s < 16; s++) m_sp[s] = 0;
    repeat (3) @(negedge clk);
    tag = "R11";
    chk("reset exc_valid", int'(exc_valid), 0);
    chk("reset exc_vec", int'(exc_vec), 0);
    chk("reset pend_vec", int'(pend_vec), 0);
    chk("reset cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: enables start cleared, so requests alone do nothing
    irq_req = '1; cycle();

    // R6: enable write aimed at system slots: error, no enable changes
    tag = "R6";
    wr_en(5, 1'b1);
    wr_en(0, 1'b1);
    wr_en(15, 1'b1);
    cycle();
    irq_req = '0;

    // R1: numbering of peripheral lines
    tag = "R1";
    wr_en(16 + 9, 1'b1);
    wr_en(16 + 0, 1'b1);
    irq_req[9] = 1'b1; cycle();
    sys_req[15] = 1'b1; irq_req = '0; cycle();
    sys_req = '0;

    // R3: level compare and tie break
    tag = "R3";
    wr_ip(9, 2);
    wr_ip(0, 5);
    irq_req[9] = 1'b1; irq_req[0] = 1'b1; cycle();
    wr_ip(0, 2);
    cycle();
    wr_ip(9, 1);
    cycle();

    // R8: system levels
    tag = "R8";
    wr_sp(15, 0);
    sys_req[15] = 1'b1; cycle();
    wr_sp(3, 15);
    wr_sp(7, 0);
    wr_sp(15, 9);
    cycle();
    sys_req[11] = 1'b1; wr_sp(11, 1); cycle();
    sys_req = '0; irq_req = '0;

    // R5: fault enables
    tag = "R5";
    sys_req[4] = 1'b1; sys_req[6] = 1'b1; cycle();
    fault_en = 3'b100; cycle();
    fault_en = 3'b101; cycle();
    fault_en = 3'b000; sys_req = '0;
    sys_req[3] = 1'b1; cycle();

    // R4: fixed order
    tag = "R4";
    irq_req = '1; wr_ip(0, 0);
    sys_req[3:1] = 3'b111; cycle();
    sys_req[1] = 1'b0; cycle();
    sys_req[2] = 1'b0; cycle();
    sys_req = '0; irq_req = '0;

    // R2: holes
    tag = "R2";
    sys_req = 16'b0011_0111_1000_0001; cycle();
    sys_req = '0; cycle();

    // R7: global mask
    tag = "R7";
    glb_mask = 1'b1;
    irq_req[9] = 1'b1; sys_req[15] = 1'b1; cycle();
    sys_req[3] = 1'b1; cycle();
    sys_req[2] = 1'b1; cycle();
    glb_mask = 1'b0; sys_req = '0; cycle();

    // R9: idle
    tag = "R9";
    irq_req = '0; cycle(); cycle();

    // R10 and R3: random traffic, every cycle compared
    tag = "R10";
    for (int k = 0; k < 4000; k++) begin
      sys_req  = 16'($urandom) & 16'($urandom);
      if (($urandom % 4) != 0) sys_req[3:1] = 3'b000;
      irq_req  = NI'($urandom);
      fault_en = 3'($urandom);
      glb_mask = (($urandom % 5) == 0);
      if (($urandom % 4) == 0) begin en_we = 1'b1; en_vec = VW'($urandom); en_val = 1'($urandom); end
      if (($urandom % 3) == 0) begin ip_we = 1'b1; ip_idx = IW'($urandom); ip_val = PW'($urandom); end
      if (($urandom % 3) == 0) begin sp_we = 1'b1; sp_slot = 4'($urandom); sp_val = PW'($urandom); end
      cycle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule